// File: doc/BRIEF.md
# Multi-Mode PWM Generator

This block drives one pulse-width-modulated output from a free-running tick clock. A two-bit mode input picks one of four behaviours. In idle the output stays low. In fixed-frequency mode the period is 256 ticks and the output is high for an 8-bit number of ticks. In pulse-density mode the output is a stream of one-tick pulses whose density follows the 8-bit duty value. In split-period mode the output has a 13-bit high duration and a separate 13-bit low duration.

Configuration inputs are sampled continuously, but each generator keeps a working copy of its settings. That copy is refreshed only when a period ends, so a change written in the middle of a period never produces a truncated or merged pulse. A change of mode restarts the newly selected generator from the start of its period.

Top module: `pwm_multimode`

## Requirements
- R1: While `rst` is high the output is low, whatever the configuration inputs carry. Reset selects the idle mode.
- R2: Mode code 0 (idle) holds the output low. It also holds every generator counter at zero.
- R3: In mode code 1 (fixed-frequency) the output repeats every 256 ticks. In each period it gives one high pulse of exactly `cfg_duty` ticks (0 gives constant low).
- R4: In mode code 2 (pulse-density), duty 0 gives a constant low output and duty 255 gives a constant high output.
- R5: In mode code 2 with duty d from 1 to 254, each 256-tick period holds exactly d high ticks. These come from the carry of an 8-bit accumulator that adds d every tick. For d up to 128 every pulse is one tick wide, and for d = 254 there are exactly two isolated one-tick lows.
- R6: In mode code 3 (split-period), each period starts with `cfg_hi_len`+1 high ticks followed by `cfg_lo_len`+1 low ticks. Both values range from 0 to 8191.
- R7: A new `cfg_mode` value shows at the output on the second rising clock edge after it is applied. The newly entered generator starts a fresh period, so in mode code 1 the first high pulse is exactly `cfg_duty` ticks long.
- R8: Changes to `cfg_duty`, `cfg_hi_len` or `cfg_lo_len` while a mode runs take effect only at the next period boundary. Every high pulse therefore has either the old length or the new length, never a mixture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; one tick per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 idle, 1 fixed-frequency, 2 pulse-density, 3 split-period |
| cfg_duty | input | 8 | Duty value for modes 1 and 2 |
| cfg_hi_len | input | 13 | High duration minus one, in ticks, for mode 3 |
| cfg_lo_len | input | 13 | Low duration minus one, in ticks, for mode 3 |
| pwm_out | output | 1 | Modulated output level |

## Verification
A mode change reaches the output two rising edges after it is driven: one edge registers the mode and one registers the generator level. The mode-change check samples exactly the first and second falling edges after the change, then counts the length of the first pulse. Duty and period updates apply at the next period boundary, one full period plus two edges later. For that reason every measurement window opens only after the new mode has been entered from idle and has settled, and each window spans a whole number of periods, so its high-tick and rising-edge counts are exact. The update checks change a value in the middle of an open window and accept only pulse lengths equal to the old or the new setting.

// File: rtl/pwm_mm_pkg.sv
package pwm_mm_pkg;

    localparam int DUTY_BITS = 8;
    localparam int PER_BITS  = 13;

    typedef enum logic [1:0] {
        MD_IDLE = 2'd0,
        MD_STD  = 2'd1,
        MD_FAST = 2'd2,
        MD_VAR  = 2'd3
    } pwm_mode_e;

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } var_phase_e;

    // True when a duty value requests a constant-high pulse-density output.
    function automatic logic duty_is_full(input logic [DUTY_BITS-1:0] d);
        return &d;
    endfunction

endpackage

// File: rtl/pwm_std_gen.sv
module pwm_std_gen #(
    parameter int W = pwm_mm_pkg::DUTY_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] duty_in,
    output logic         level,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] duty_w_o
);
    logic [W-1:0] cnt;
    logic [W-1:0] duty_w;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt    <= '0;
            duty_w <= duty_in;
            level  <= 1'b0;
        end else begin
            level <= (cnt < duty_w);
            cnt   <= cnt + 1'b1;
            if (&cnt) begin
                duty_w <= duty_in;
            end
        end
    end

    assign cnt_o    = cnt;
    assign duty_w_o = duty_w;
endmodule

// File: rtl/pwm_fast_gen.sv
module pwm_fast_gen #(
    parameter int W = pwm_mm_pkg::DUTY_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] duty_in,
    output logic         level,
    output logic [W-1:0] duty_w_o
);
    logic [W-1:0] acc;
    logic [W-1:0] phase;
    logic [W-1:0] duty_w;
    logic [W:0]   sum;

    assign sum = {1'b0, acc} + {1'b0, duty_w};

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            acc    <= '0;
            phase  <= '0;
            duty_w <= duty_in;
            level  <= 1'b0;
        end else begin
            level <= pwm_mm_pkg::duty_is_full(duty_w) | sum[W];
            phase <= phase + 1'b1;
            if (&phase) begin
                acc    <= '0;
                duty_w <= duty_in;
            end else begin
                acc <= sum[W-1:0];
            end
        end
    end

    assign duty_w_o = duty_w;
endmodule

// File: rtl/pwm_var_gen.sv
module pwm_var_gen #(
    parameter int P = pwm_mm_pkg::PER_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [P-1:0] hi_in,
    input  logic [P-1:0] lo_in,
    output logic         level,
    output logic         in_hi_o,
    output logic [P-1:0] cnt_o,
    output logic [P-1:0] hi_w_o,
    output logic [P-1:0] lo_w_o
);
    import pwm_mm_pkg::*;

    var_phase_e   ph;
    logic [P-1:0] cnt;
    logic [P-1:0] hi_w;
    logic [P-1:0] lo_w;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ph    <= PH_HIGH;
            cnt   <= '0;
            hi_w  <= hi_in;
            lo_w  <= lo_in;
            level <= 1'b0;
        end else begin
            level <= (ph == PH_HIGH);
            if (ph == PH_HIGH) begin
                if (cnt == hi_w) begin
                    cnt <= '0;
                    ph  <= PH_LOW;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                if (cnt == lo_w) begin
                    cnt  <= '0;
                    ph   <= PH_HIGH;
                    hi_w <= hi_in;
                    lo_w <= lo_in;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign in_hi_o = (ph == PH_HIGH);
    assign cnt_o   = cnt;
    assign hi_w_o  = hi_w;
    assign lo_w_o  = lo_w;
endmodule

// File: rtl/pwm_multimode.sv
module pwm_multimode #(
    parameter int DUTY_W = pwm_mm_pkg::DUTY_BITS,
    parameter int PER_W  = pwm_mm_pkg::PER_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic [DUTY_W-1:0] cfg_duty,
    input  logic [PER_W-1:0]  cfg_hi_len,
    input  logic [PER_W-1:0]  cfg_lo_len,
    output logic              pwm_out
);
    import pwm_mm_pkg::*;

    localparam int NUM_GEN = 3;

    pwm_mode_e         mode_q;
    logic [NUM_GEN-1:0] lvl;

    logic [DUTY_W-1:0] std_cnt;
    logic [DUTY_W-1:0] std_duty_w;
    logic [DUTY_W-1:0] fast_duty_w;
    logic              var_in_hi;
    logic [PER_W-1:0]  var_cnt;
    logic [PER_W-1:0]  var_hi_w;
    logic [PER_W-1:0]  var_lo_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MD_IDLE;
        end else begin
            mode_q <= pwm_mode_e'(cfg_mode);
        end
    end

    pwm_std_gen #(.W(DUTY_W)) std_i (
        .clk      (clk),
        .rst      (rst),
        .en       (mode_q == MD_STD),
        .duty_in  (cfg_duty),
        .level    (lvl[0]),
        .cnt_o    (std_cnt),
        .duty_w_o (std_duty_w)
    );

    pwm_fast_gen #(.W(DUTY_W)) fast_i (
        .clk      (clk),
        .rst      (rst),
        .en       (mode_q == MD_FAST),
        .duty_in  (cfg_duty),
        .level    (lvl[1]),
        .duty_w_o (fast_duty_w)
    );

    pwm_var_gen #(.P(PER_W)) var_i (
        .clk     (clk),
        .rst     (rst),
        .en      (mode_q == MD_VAR),
        .hi_in   (cfg_hi_len),
        .lo_in   (cfg_lo_len),
        .level   (lvl[2]),
        .in_hi_o (var_in_hi),
        .cnt_o   (var_cnt),
        .hi_w_o  (var_hi_w),
        .lo_w_o  (var_lo_w)
    );

    // Only the enabled generator can hold a high level.
    assign pwm_out = |lvl;
endmodule

// File: rtl/pwm_multimode_chk.sv
module pwm_multimode_chk #(
    parameter int DW = pwm_mm_pkg::DUTY_BITS,
    parameter int PW = pwm_mm_pkg::PER_BITS
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode_q,
    input logic          pwm_out,
    input logic [DW-1:0] std_cnt,
    input logic [DW-1:0] std_duty_w,
    input logic [DW-1:0] fast_duty_w,
    input logic          var_in_hi,
    input logic [PW-1:0] var_cnt,
    input logic [PW-1:0] var_hi_w,
    input logic [PW-1:0] var_lo_w
);
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd0) |=> !pwm_out); // R2

    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mode_q != 2'd1) |=> (std_cnt == '0)); // R2

    AST_FAST_FULL: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd2 && (&fast_duty_w)) |=> pwm_out); // R4

    AST_FAST_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd2 && fast_duty_w == '0) |=> !pwm_out); // R4

    AST_VAR_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd3) |-> (var_in_hi ? (var_cnt <= var_hi_w) : (var_cnt <= var_lo_w))); // R6

    AST_STD_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd1 && !(&std_cnt)) |=> $stable(std_duty_w)); // R8

    AST_VAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd3 && !(!var_in_hi && var_cnt == var_lo_w))
        |=> ($stable(var_hi_w) && $stable(var_lo_w))); // R8
endmodule

bind pwm_multimode pwm_multimode_chk #(.DW(DUTY_W), .PW(PER_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .mode_q      (mode_q),
    .pwm_out     (pwm_out),
    .std_cnt     (std_cnt),
    .std_duty_w  (std_duty_w),
    .fast_duty_w (fast_duty_w),
    .var_in_hi   (var_in_hi),
    .var_cnt     (var_cnt),
    .var_hi_w    (var_hi_w),
    .var_lo_w    (var_lo_w)
);

// File: tb/pwm_multimode_tb_top.sv
module pwm_multimode_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_mode = 2'd0;
    logic [7:0]  cfg_duty = 8'd0;
    logic [12:0] cfg_hi_len = 13'd0;
    logic [12:0] cfg_lo_len = 13'd0;
    logic        pwm_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    pwm_multimode dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_mode   (cfg_mode),
        .cfg_duty   (cfg_duty),
        .cfg_hi_len (cfg_hi_len),
        .cfg_lo_len (cfg_lo_len),
        .pwm_out    (pwm_out)
    );

    typedef struct {
        string req;
        int    n;
        int    highs;
        int    rises;
        int    run_a;
        int    run_b;
    } exp_t;

    exp_t sb_q[$];
    event go;
    bit   mon_busy = 1'b0;

    task automatic check(string req, bit ok, int act, int exp, string what);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Monitor: pops one expected item per window and compares it with the output.
    initial begin
        forever begin
            exp_t it;
            bit   prev;
            bit   cur;
            bit   inrun;
            int   h;
            int   r;
            int   run;
            int   bad;
            int   badlen;
            @(go);
            it     = sb_q.pop_front();
            prev   = pwm_out;
            h      = 0;
            r      = 0;
            run    = 0;
            bad    = 0;
            badlen = 0;
            inrun  = 1'b0;
            for (int i = 0; i < it.n; i++) begin
                @(negedge clk);
                cur = pwm_out;
                if (cur) h++;
                if (cur && !prev) begin
                    r++;
                    inrun = 1'b1;
                    run   = 0;
                end
                if (cur && inrun) run++;
                if (!cur && prev && inrun) begin
                    if (it.run_a > 0 && run != it.run_a && run != it.run_b) begin
                        bad++;
                        badlen = run;
                    end
                    inrun = 1'b0;
                end
                prev = cur;
            end
            if (it.highs >= 0) check(it.req, h == it.highs, h, it.highs, "high ticks");
            if (it.rises >= 0) check(it.req, r == it.rises, r, it.rises, "rising edges");
            if (it.run_a > 0)  check(it.req, bad == 0, badlen, it.run_a, "pulse length");
            mon_busy = 1'b0;
        end
    end

    // Driver helpers
    task automatic launch(string req, int n, int highs, int rises, int ra, int rb);
        exp_t e;
        e.req = req; e.n = n; e.highs = highs; e.rises = rises; e.run_a = ra; e.run_b = rb;
        sb_q.push_back(e);
        @(negedge clk);
        mon_busy = 1'b1;
        -> go;
    endtask

    task automatic wait_window();
        wait (!mon_busy);
    endtask

    task automatic measure(string req, int n, int highs, int rises, int ra, int rb);
        launch(req, n, highs, rises, ra, rb);
        wait_window();
    endtask

    task automatic enter_mode(int m, int d, int hi, int lo);
        @(negedge clk);
        cfg_mode = 2'd0;
        repeat (3) @(negedge clk);
        cfg_duty   = d[7:0];
        cfg_hi_len = hi[12:0];
        cfg_lo_len = lo[12:0];
        cfg_mode   = m[1:0];
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int cnt;
        // R1: reset forces low output even with an active configuration.
        cfg_mode = 2'd1;
        cfg_duty = 8'd200;
        begin
            int hs;
            hs = 0;
            repeat (6) begin
                @(negedge clk);
                if (pwm_out) hs++;
            end
            check("R1", hs == 0, hs, 0, "high ticks during reset");
        end
        cfg_mode = 2'd0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", pwm_out == 1'b0, pwm_out, 0, "output after reset");

        // R2: idle holds low for any duty / period setting.
        enter_mode(0, 128, 0, 0);
        measure("R2", 300, 0, 0, 0, 0);

        // R3: fixed-frequency mode.
        enter_mode(1, 0, 0, 0);
        measure("R3", 512, 0, 0, 0, 0);
        enter_mode(1, 100, 0, 0);
        measure("R3", 512, 200, 2, 100, 100);
        enter_mode(1, 255, 0, 0);
        measure("R3", 512, 510, 2, 255, 255);

        // R4: pulse-density extremes.
        enter_mode(2, 0, 0, 0);
        measure("R4", 512, 0, 0, 0, 0);
        enter_mode(2, 255, 0, 0);
        measure("R4", 512, 512, 0, 0, 0);

        // R5: pulse-density intermediate values.
        enter_mode(2, 1, 0, 0);
        measure("R5", 256, 1, 1, 1, 1);
        enter_mode(2, 64, 0, 0);
        measure("R5", 256, 64, 64, 1, 1);
        enter_mode(2, 128, 0, 0);
        measure("R5", 256, 128, 128, 1, 1);
        enter_mode(2, 254, 0, 0);
        measure("R5", 512, 508, 4, 0, 0);
        enter_mode(2, 100, 0, 0);
        measure("R5", 512, 200, -1, 1, 1);

        // R6: split-period mode.
        enter_mode(3, 0, 3, 5);
        measure("R6", 100, 40, 10, 4, 4);
        enter_mode(3, 0, 0, 0);
        measure("R6", 256, 128, 128, 1, 1);
        enter_mode(3, 0, 8191, 0);
        measure("R6", 8193, 8192, 1, 0, 0);

        // R7: mode change latency and fresh period.
        enter_mode(1, 37, 0, 0);
        repeat (100) @(negedge clk);
        cfg_mode = 2'd0;
        repeat (3) @(negedge clk);
        cfg_mode = 2'd1;
        @(negedge clk);
        check("R7", pwm_out == 1'b0, pwm_out, 0, "output one edge after mode change");
        @(negedge clk);
        check("R7", pwm_out == 1'b1, pwm_out, 1, "output two edges after mode change");
        cnt = 1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!pwm_out) break;
            cnt++;
        end
        check("R7", cnt == 37, cnt, 37, "first pulse length after entry");

        // R8: mid-period updates in fixed-frequency mode.
        enter_mode(1, 64, 0, 0);
        repeat (300) @(negedge clk);
        launch("R8", 1024, -1, -1, 64, 200);
        repeat (100) @(negedge clk);
        cfg_duty = 8'd200;
        wait_window();

        // R8: mid-period updates in split-period mode.
        enter_mode(3, 0, 10, 6);
        repeat (50) @(negedge clk);
        launch("R8", 600, -1, -1, 11, 41);
        repeat (7) @(negedge clk);
        cfg_hi_len = 13'd40;
        wait_window();

        done_flag = 1'b1;
        report();
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

endmodule